// File: doc/BRIEF.md
# Dimming Standby and Reference Controller

This block sits behind the converter that digitizes a dimming voltage. Every clock it takes the dimming level as a millivolt code and turns it into the regulation reference for the current loop and the peak-current limit. It also flags the open-loop minimum-current region at the bottom of the dimming range. A small sequencer turns the switch drive off as soon as the level drops into the off band. If the level stays low for a programmable number of milliseconds, the sequencer moves into a low-power standby state. It leaves standby as soon as the level climbs past a higher wake threshold, and it then asks for a fresh start-up.

The reference follows a linear law. It is zero at 250 mV of dimming input and grows by 1 mV for every 12.5 mV of input, up to 180 mV at a 2500 mV input. Any input above 2500 mV is treated as 2500 mV. The current limit sits 30 mV above the reference but never below 80 mV. The standby delay is counted by a prescaler that divides the clock down to milliseconds. Both the prescaler length and the delay in milliseconds are parameters.

Top module: `dim_standby_ctrl`

## Requirements
- R1: With the dimming input d at or above 250, `refMv` one cycle later equals floor((min(d,2500) − 250) × 2 / 25), so 2500 and above give 180 and 263 gives 1.
- R2: With d below 250, `refMv` is 0 and `openLoop` is 1 one cycle later. With d at or above 250, `openLoop` is 0 one cycle later.
- R3: `limMv` always equals the larger of `refMv` + 30 and 80, and it is updated in the same cycle as `refMv`.
- R4: While the drive is enabled, an input below 75 clears `drvEn` on the next cycle.
- R5: After the drive is cleared by R4, `standby` rises exactly CLKS_PER_MS × DELAY_MS cycles later, provided the input stays at or below 100 for the whole time.
- R6: During the hold-off delay, an input above 100 sets `drvEn` on the next cycle. Standby is not entered and no restart is requested. The next hold-off starts its delay from zero.
- R7: In standby, an input above 100 clears `standby` and sets `drvEn` on the next cycle. In that same cycle `restartReq` is high, and only for that one cycle.
- R8: An input from 75 to 100 inclusive causes no change of state. A running drive stays on, a hold-off keeps counting, and standby is kept.
- R9: During reset and right after it, the outputs are `standby`=1, `drvEn`=0, `restartReq`=0, `refMv`=0, `limMv`=80 and `openLoop`=1.
- R10: `drvEn` and `standby` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dimMv | input | 12 | Dimming level in millivolts, sampled every clock |
| refMv | output | 8 | Current-regulation reference in millivolts |
| limMv | output | 8 | Peak-current limit in millivolts |
| drvEn | output | 1 | Switch drive enable |
| openLoop | output | 1 | Open-loop minimum-current mode |
| standby | output | 1 | Low-power standby state |
| restartReq | output | 1 | One-cycle request for a fresh start-up on wake |

## Verification
The properties assume that `dimMv` is a clean synchronous code that changes only between clock edges and never holds unknown bits. Each property relates the sampled input to the outputs one cycle later. The stimulus changes the input only on the falling edge. It holds each randomly chosen level for a random run of up to 250 cycles, so that hold-off delays run out often enough to reach standby. Levels are drawn mostly from the band around the 75 and 100 thresholds and the 250 knee, and partly from the full 12-bit range, so that inputs above full scale are exercised too.

// File: rtl/dim_standby_pkg.sv
package dim_standby_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_HOLD  = 2'd1,
    PS_SLEEP = 2'd2
  } pwrState_t;

  // strobes from the sequencer to the delay timer
  typedef struct packed {
    logic clear;
    logic count;
  } timerCmd_t;
endpackage

// File: rtl/dim_ref_path.sv
module dim_ref_path #(
  parameter int DIM_W        = 12,
  parameter int REF_W        = 8,
  parameter int KNEE_MV      = 250,
  parameter int FULL_MV      = 2500,
  parameter int GAIN_X2      = 25,
  parameter int LIM_OFS_MV   = 30,
  parameter int LIM_FLOOR_MV = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIM_W-1:0] dimMv,
  output logic [REF_W-1:0] refMv,
  output logic [REF_W-1:0] limMv,
  output logic             openLoop
);
  localparam int SPAN_W = DIM_W + 2;

  logic             belowKnee;
  logic [DIM_W-1:0] clipped;
  logic [SPAN_W-1:0] spanX2;
  logic [SPAN_W-1:0] quot;
  logic [REF_W-1:0] refNext;
  logic [REF_W:0]   limSum;
  logic [REF_W-1:0] limNext;

  always_comb begin
    belowKnee = dimMv < DIM_W'(KNEE_MV);
    clipped   = (dimMv > DIM_W'(FULL_MV)) ? DIM_W'(FULL_MV) : dimMv;
    spanX2    = belowKnee ? '0
                          : {1'b0, (clipped - DIM_W'(KNEE_MV)), 1'b0};
    quot      = spanX2 / SPAN_W'(GAIN_X2);
    refNext   = quot[REF_W-1:0];
    limSum    = {1'b0, refNext} + (REF_W+1)'(LIM_OFS_MV);
    limNext   = (limSum < (REF_W+1)'(LIM_FLOOR_MV)) ? REF_W'(LIM_FLOOR_MV)
                                                     : limSum[REF_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refMv    <= '0;
      limMv    <= REF_W'(LIM_FLOOR_MV);
      openLoop <= 1'b1;
    end else begin
      refMv    <= refNext;
      limMv    <= limNext;
      openLoop <= belowKnee;
    end
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer
  import dim_standby_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int DELAY_MS    = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      done
);
  localparam int PRE_W = $clog2(CLKS_PER_MS + 1);
  localparam int MS_W  = $clog2(DELAY_MS + 1);

  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;
  logic             msTick;

  assign msTick = preCnt == PRE_W'(CLKS_PER_MS - 1);
  assign done   = cmd.count && msTick && (msCnt == MS_W'(DELAY_MS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (cmd.clear) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (cmd.count) begin
      if (msTick) begin
        preCnt <= '0;
        msCnt  <= msCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
  import dim_standby_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ENA_MV = 75,
  parameter int DIS_MV = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIM_W-1:0] dimMv,
  input  logic             tmrDone,
  output timerCmd_t        tmrCmd,
  output logic             drvEn,
  output logic             standby,
  output logic             restartReq
);
  pwrState_t state, nextState;
  logic belowEna, aboveDis;

  assign belowEna = dimMv < DIM_W'(ENA_MV);
  assign aboveDis = dimMv > DIM_W'(DIS_MV);

  always_comb begin
    nextState    = state;
    tmrCmd.clear = 1'b1;
    tmrCmd.count = 1'b0;
    unique case (state)
      PS_RUN:   if (belowEna) nextState = PS_HOLD;
      PS_HOLD: begin
        if (aboveDis) begin
          nextState = PS_RUN;
        end else begin
          tmrCmd.clear = 1'b0;
          tmrCmd.count = 1'b1;
          if (tmrDone) nextState = PS_SLEEP;
        end
      end
      PS_SLEEP: if (aboveDis) nextState = PS_RUN;
      default:  nextState = PS_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= PS_SLEEP;
      restartReq <= 1'b0;
    end else begin
      state      <= nextState;
      restartReq <= (state == PS_SLEEP) && aboveDis;
    end
  end

  assign drvEn   = state == PS_RUN;
  assign standby = state == PS_SLEEP;
endmodule

// File: rtl/dim_standby_ctrl.sv
module dim_standby_ctrl
  import dim_standby_pkg::*;
#(
  parameter int DIM_W        = 12,
  parameter int REF_W        = 8,
  parameter int KNEE_MV      = 250,
  parameter int FULL_MV      = 2500,
  parameter int GAIN_X2      = 25,
  parameter int LIM_OFS_MV   = 30,
  parameter int LIM_FLOOR_MV = 80,
  parameter int ENA_MV       = 75,
  parameter int DIS_MV       = 100,
  parameter int CLKS_PER_MS  = 125000,
  parameter int DELAY_MS     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIM_W-1:0] dimMv,
  output logic [REF_W-1:0] refMv,
  output logic [REF_W-1:0] limMv,
  output logic             drvEn,
  output logic             openLoop,
  output logic             standby,
  output logic             restartReq
);
  timerCmd_t tmrCmd;
  logic      tmrDone;

  dim_ref_path #(
    .DIM_W(DIM_W), .REF_W(REF_W), .KNEE_MV(KNEE_MV), .FULL_MV(FULL_MV),
    .GAIN_X2(GAIN_X2), .LIM_OFS_MV(LIM_OFS_MV), .LIM_FLOOR_MV(LIM_FLOOR_MV)
  ) u_ref (
    .clk(clk), .rstN(rstN), .dimMv(dimMv),
    .refMv(refMv), .limMv(limMv), .openLoop(openLoop)
  );

  standby_seq #(
    .DIM_W(DIM_W), .ENA_MV(ENA_MV), .DIS_MV(DIS_MV)
  ) u_seq (
    .clk(clk), .rstN(rstN), .dimMv(dimMv), .tmrDone(tmrDone),
    .tmrCmd(tmrCmd), .drvEn(drvEn), .standby(standby),
    .restartReq(restartReq)
  );

  hold_timer #(
    .CLKS_PER_MS(CLKS_PER_MS), .DELAY_MS(DELAY_MS)
  ) u_tmr (
    .clk(clk), .rstN(rstN), .cmd(tmrCmd), .done(tmrDone)
  );
endmodule

// File: rtl/dim_standby_chk.sv
module dim_standby_chk #(
  parameter int DIM_W        = 12,
  parameter int REF_W        = 8,
  parameter int KNEE_MV      = 250,
  parameter int FULL_MV      = 2500,
  parameter int GAIN_X2      = 25,
  parameter int LIM_FLOOR_MV = 80,
  parameter int ENA_MV       = 75,
  parameter int DIS_MV       = 100
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIM_W-1:0] dimMv,
  input logic [REF_W-1:0] refMv,
  input logic [REF_W-1:0] limMv,
  input logic             drvEn,
  input logic             openLoop,
  input logic             standby,
  input logic             restartReq
);
  localparam int REF_MAX = ((FULL_MV - KNEE_MV) * 2) / GAIN_X2;

  p_ref_ceiling_r1: assert property (@(posedge clk) disable iff (!rstN)
    int'(refMv) <= REF_MAX);

  p_open_loop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dimMv < DIM_W'(KNEE_MV)) |=> (openLoop && refMv == '0));

  p_lim_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(limMv) >= LIM_FLOOR_MV);

  p_drive_kill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dimMv < DIM_W'(ENA_MV)) |=> !drvEn);

  p_sleep_after_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |-> $past(!drvEn && !standby));

  p_abort_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!drvEn && !standby && dimMv > DIM_W'(DIS_MV)) |=> (drvEn && !restartReq));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (standby && dimMv > DIM_W'(DIS_MV)) |=> (drvEn && restartReq));

  p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);

  p_band_keeps_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && dimMv >= DIM_W'(ENA_MV)) |=> drvEn);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(drvEn && standby));
endmodule

bind dim_standby_ctrl dim_standby_chk #(
  .DIM_W(DIM_W), .REF_W(REF_W), .KNEE_MV(KNEE_MV), .FULL_MV(FULL_MV),
  .GAIN_X2(GAIN_X2), .LIM_FLOOR_MV(LIM_FLOOR_MV),
  .ENA_MV(ENA_MV), .DIS_MV(DIS_MV)
) u_chk (
  .clk(clk), .rstN(rstN), .dimMv(dimMv), .refMv(refMv), .limMv(limMv),
  .drvEn(drvEn), .openLoop(openLoop), .standby(standby),
  .restartReq(restartReq)
);

// File: tb/dim_standby_ctrl_tb.sv
module dim_standby_ctrl_tb;
  localparam int CPM   = 20;
  localparam int DMS   = 10;
  localparam int TOTAL = CPM * DMS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] dimMv = '0;
  logic [7:0]  refMv, limMv;
  logic        drvEn, openLoop, standby, restartReq;

  int nChecks = 0;
  int nFail = 0;

  // model state: 0 run, 1 hold-off, 2 standby
  int mState = 2;
  int mCnt = 0;
  int mRef = 0;
  int mLim = 80;
  int mOl = 1;
  int mRst = 0;

  always #4 clk = ~clk;

  dim_standby_ctrl #(.CLKS_PER_MS(CPM), .DELAY_MS(DMS)) u_dut (
    .clk(clk), .rstN(rstN), .dimMv(dimMv), .refMv(refMv), .limMv(limMv),
    .drvEn(drvEn), .openLoop(openLoop), .standby(standby),
    .restartReq(restartReq)
  );

  function automatic int expRef(input int d);
    int c;
    if (d < 250) return 0;
    c = (d > 2500) ? 2500 : d;
    return ((c - 250) * 2) / 25;
  endfunction

  function automatic int expLim(input int r);
    return (r + 30 < 80) ? 80 : r + 30;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge(input int d);
    mRst = 0;
    case (mState)
      0: if (d < 75) begin mState = 1; mCnt = 0; end
      1: begin
        if (d > 100) mState = 0;
        else begin
          mCnt++;
          if (mCnt == TOTAL) mState = 2;
        end
      end
      default: if (d > 100) begin mState = 0; mRst = 1; end
    endcase
    mRef = expRef(d);
    mLim = expLim(mRef);
    mOl  = (d < 250) ? 1 : 0;
  endtask

  task automatic compareAll();
    chk("R1 refMv", int'(refMv), mRef);
    chk("R2 openLoop", int'(openLoop), mOl);
    chk("R3 limMv", int'(limMv), mLim);
    chk("R4 drvEn", int'(drvEn), (mState == 0) ? 1 : 0);
    chk("R5 standby", int'(standby), (mState == 2) ? 1 : 0);
    chk("R7 restartReq", int'(restartReq), mRst);
    chk("R10 exclusive", int'(drvEn && standby), 0);
  endtask

  // drive on the falling edge, model the rising edge, compare on next fall
  task automatic step(input int d);
    dimMv = 12'(d);
    @(posedge clk);
    modelEdge(d);
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 standby", int'(standby), 1);
    chk("R9 drvEn", int'(drvEn), 0);
    chk("R9 restartReq", int'(restartReq), 0);
    chk("R9 refMv", int'(refMv), 0);
    chk("R9 limMv", int'(limMv), 80);
    chk("R9 openLoop", int'(openLoop), 1);
    rstN = 1'b1;
    repeat (3) step(0);
    chk("R9 standby after reset", int'(standby), 1);

    // R7 wake from standby
    step(2500);
    chk("R7 wake drvEn", int'(drvEn), 1);
    chk("R7 wake pulse", int'(restartReq), 1);
    chk("R1 full scale ref", int'(refMv), 180);
    chk("R3 full scale lim", int'(limMv), 210);
    step(2500);
    chk("R7 pulse ends", int'(restartReq), 0);

    // R1 / R2 / R3 corners
    step(250);  chk("R2 knee openLoop", int'(openLoop), 0); chk("R1 knee ref", int'(refMv), 0);
    step(249);  chk("R2 below knee openLoop", int'(openLoop), 1);
    step(262);  chk("R1 262 ref", int'(refMv), 0);
    step(263);  chk("R1 263 ref", int'(refMv), 1);
    step(4095); chk("R1 clip ref", int'(refMv), 180);
    step(1000); chk("R1 mid ref", int'(refMv), 60); chk("R3 mid lim", int'(limMv), 90);
    step(500);  chk("R3 floor lim", int'(limMv), 80);

    // R8 band keeps drive on
    repeat (20) step(75);
    chk("R8 run in band", int'(drvEn), 1);
    // R4 kill
    step(74);
    chk("R4 drive off", int'(drvEn), 0);
    // R5 with band values mixed in (R8 hold-off keeps counting)
    for (int i = 1; i < TOTAL; i++) step((i % 3 == 0) ? 100 : 0);
    chk("R5 not yet standby", int'(standby), 0);
    step(0);
    chk("R5 standby on time", int'(standby), 1);
    repeat (5) step(100);
    chk("R8 standby kept", int'(standby), 1);
    step(101);
    chk("R7 wake at 101", int'(restartReq), 1);

    // R6 abort hold-off, then delay restarts from zero
    step(10);
    repeat (120) step(50);
    step(101);
    chk("R6 abort drvEn", int'(drvEn), 1);
    chk("R6 abort no standby", int'(standby), 0);
    chk("R6 abort no restart", int'(restartReq), 0);
    step(0);
    for (int i = 1; i < TOTAL; i++) step(0);
    chk("R6 fresh delay not done", int'(standby), 0);
    step(0);
    chk("R6 fresh delay done", int'(standby), 1);

    // random runs
    for (int r = 0; r < 400; r++) begin
      int lvl, len;
      case ($urandom % 4)
        0, 1: lvl = $urandom % 130;
        2:    lvl = 200 + ($urandom % 100);
        default: lvl = $urandom % 4096;
      endcase
      len = 1 + ($urandom % 250);
      for (int k = 0; k < len; k++) step(lvl);
    end
    finishRun();
  end
endmodule